// File: doc/BRIEF.md
# Programmable Clock Post-Divider and Output Router

This block sits behind a frequency synthesizer loop. It receives the fast oscillator clock as its own clock, `clk_i`. The reference clock comes in on `ref_i` as a level that is sampled in that domain. The block divides by an even programmable ratio and routes the selected sources to a main output and to a secondary output.

Two configuration sets are held side by side. Each set carries:
- a post-divide field P;
- a reference divider value R and a feedback divider value M, both handed to the external loop;
- a source code for each output.

A synchronised frequency-select input picks the active set at run time.

One multi-purpose pin serves as an output-enable input, a power-down input or the secondary clock output, according to a static mode code. A pin driver enable tells the pad when the block is driving that pin. Both output clocks are registered. A change of active set waits until both outputs are low.

Top module: `clk_post_router`

## Requirements
- R1: `fsel_i` high selects set 1 (array index 0); low selects set 2 (index 1). `r_div_o` and `m_div_o` always show the R and M fields of the active set.
- R2: The active set changes only on a clock edge at which `clk0_o` and `clk1_o` are both low.
- R3: Main source code 0 (code 3 behaves the same) gives the oscillator clock divided by 2P. `clk0_o` is then high for P cycles and low for P cycles.
- R4: A P field of 0 divides as if P were 1, so the divider keeps running.
- R5: Main source code 1 passes the reference straight through. `clk0_o` equals `ref_i` as sampled two rising edges earlier.
- R6: Main source code 2 gives the reference divided by 2P. `clk0_o` toggles once every P rising edges of the sampled reference.
- R7: The secondary source code selects one of four sources:
  - 0: the sampled reference;
  - 1: the reference divided by 2;
  - 2: the main source;
  - 3: the main source divided by 2.
- R8: Pin mode 0 (code 3 behaves the same) makes the pin an enable. A synchronised low on `mfp_i` forces both outputs low while the dividers keep counting.
- R9: Pin mode 1 makes the pin a power-down. A synchronised low forces both outputs low and clears every divider and sampling register. On release, counting restarts from zero.
- R10: `mfp_oe_o` is high exactly when the pin mode is 2. In every other mode `clk1_o` is low.
- R11: `fsel_i` and `mfp_i` each pass through a two-flop synchroniser whose reset value is high.
- R12: While `rst_ni` is low, both clocks are low and set 1 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock level, sampled on clk_i |
| fsel_i | input | 1 | Set select: 1 = set 1, 0 = set 2 |
| pin_mode_i | input | 2 | Pin function: 0 enable, 1 power-down, 2 clock out, 3 as 0 |
| mfp_i | input | 1 | Pin level seen as input |
| p_i | input | 2xP_W | Post-divide field per set |
| r_i | input | 2xR_W | Reference divider value per set |
| m_i | input | 2xM_W | Feedback divider value per set |
| main_sel_i | input | 2x2 | Main source code per set |
| sec_sel_i | input | 2x2 | Secondary source code per set |
| clk0_o | output | 1 | Main clock output |
| clk1_o | output | 1 | Secondary clock output (pin data) |
| mfp_oe_o | output | 1 | Pin driver enable |
| r_div_o | output | R_W | R of the active set |
| m_div_o | output | M_W | M of the active set |

## Verification
A set switch and a gating event can land on the same edge. The bench provokes this by lowering `fsel_i` together with a power-down request, and later releasing both together. Because both outputs fall low under power-down, the switch is let through at once, and the new P and source codes must take effect exactly as counting restarts from zero. The cycle model in the bench tracks the synchroniser latencies and the low-output switching condition. It is compared against every output on every cycle across these overlaps.

// File: rtl/clk_post_router_pkg.sv
package clk_post_router_pkg;
  localparam int unsigned NUM_SETS = 2;

  typedef enum logic [1:0] {
    PIN_OE  = 2'd0,
    PIN_PD  = 2'd1,
    PIN_CLK = 2'd2,
    PIN_RSV = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    MAIN_VCO    = 2'd0,
    MAIN_REF    = 2'd1,
    MAIN_REFDIV = 2'd2,
    MAIN_ALT    = 2'd3
  } main_src_e;

  typedef enum logic [1:0] {
    SEC_REF      = 2'd0,
    SEC_REFHALF  = 2'd1,
    SEC_MAIN     = 2'd2,
    SEC_MAINHALF = 2'd3
  } sec_src_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/even_div.sv
module even_div #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         div_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;
  logic         tog_q;

  // zero ratio runs as one
  assign lim = (ratio_i == '0) ? W'(1) : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (en_i) begin
      // >= keeps it safe when the ratio shrinks mid-count
      if (cnt_q >= lim - W'(1)) begin
        cnt_q <= '0;
        tog_q <= ~tog_q;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign div_o = tog_q;

  // R9
  div_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!div_o && cnt_q == '0));
endmodule

// File: rtl/set_select.sv
module set_select #(
  parameter int unsigned P_W = 5,
  parameter int unsigned R_W = 8,
  parameter int unsigned M_W = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fsel_s_i,
  input  logic                hold_i,
  input  logic [1:0][P_W-1:0] p_i,
  input  logic [1:0][R_W-1:0] r_i,
  input  logic [1:0][M_W-1:0] m_i,
  input  logic [1:0][1:0]     main_sel_i,
  input  logic [1:0][1:0]     sec_sel_i,
  output logic [P_W-1:0]      p_o,
  output logic [R_W-1:0]      r_o,
  output logic [M_W-1:0]      m_o,
  output logic [1:0]          main_sel_o,
  output logic [1:0]          sec_sel_o
);
  logic act_q;

  // switch only while both outputs sit low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= 1'b0;
    else if (!hold_i) act_q <= ~fsel_s_i;
  end

  assign p_o        = p_i[act_q];
  assign r_o        = r_i[act_q];
  assign m_o        = m_i[act_q];
  assign main_sel_o = main_sel_i[act_q];
  assign sec_sel_o  = sec_sel_i[act_q];

  // R2
  set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(act_q));
endmodule

// File: rtl/clk_route.sv
module clk_route
  import clk_post_router_pkg::*;
#(
  parameter int unsigned P_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           gate_i,
  input  logic           clk_mode_i,
  input  logic           ref_i,
  input  logic [P_W-1:0] p_i,
  input  logic [1:0]     main_sel_i,
  input  logic [1:0]     sec_sel_i,
  output logic           clk0_o,
  output logic           clk1_o
);
  logic ref_r, ref_p, main_p;
  logic vco_div, ref_div, ref_half, main_half;
  logic main_src, sec_src;
  logic ref_tick, main_rise;

  assign ref_tick  = ref_r & ~ref_p;
  assign main_rise = main_src & ~main_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_r  <= 1'b0;
      ref_p  <= 1'b0;
      main_p <= 1'b0;
    end else if (!run_i) begin
      ref_r  <= 1'b0;
      ref_p  <= 1'b0;
      main_p <= 1'b0;
    end else begin
      ref_r  <= ref_i;
      ref_p  <= ref_r;
      main_p <= main_src;
    end
  end

  even_div #(.W(P_W)) u_vco_div (
    .clk_i, .rst_ni, .clr_i(~run_i), .en_i(1'b1),
    .ratio_i(p_i), .div_o(vco_div));

  even_div #(.W(P_W)) u_ref_div (
    .clk_i, .rst_ni, .clr_i(~run_i), .en_i(ref_tick),
    .ratio_i(p_i), .div_o(ref_div));

  even_div #(.W(1)) u_ref_half (
    .clk_i, .rst_ni, .clr_i(~run_i), .en_i(ref_tick),
    .ratio_i(1'b1), .div_o(ref_half));

  even_div #(.W(1)) u_main_half (
    .clk_i, .rst_ni, .clr_i(~run_i), .en_i(main_rise),
    .ratio_i(1'b1), .div_o(main_half));

  always_comb begin
    unique case (main_src_e'(main_sel_i))
      MAIN_REF:    main_src = ref_r;
      MAIN_REFDIV: main_src = ref_div;
      default:     main_src = vco_div;
    endcase
  end

  always_comb begin
    unique case (sec_src_e'(sec_sel_i))
      SEC_REF:     sec_src = ref_r;
      SEC_REFHALF: sec_src = ref_half;
      SEC_MAIN:    sec_src = main_src;
      default:     sec_src = main_half;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk0_o <= 1'b0;
      clk1_o <= 1'b0;
    end else begin
      clk0_o <= run_i & gate_i & main_src;
      clk1_o <= run_i & gate_i & clk_mode_i & sec_src;
    end
  end

  // R9
  pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!clk0_o && !clk1_o));

  // R8
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> (!clk0_o && !clk1_o));

  // R10
  sec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_mode_i |=> !clk1_o);
endmodule

// File: rtl/clk_post_router.sv
module clk_post_router
  import clk_post_router_pkg::*;
#(
  parameter int unsigned P_W         = 5,
  parameter int unsigned R_W         = 8,
  parameter int unsigned M_W         = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_i,
  input  logic                fsel_i,
  input  logic [1:0]          pin_mode_i,
  input  logic                mfp_i,
  input  logic [1:0][P_W-1:0] p_i,
  input  logic [1:0][R_W-1:0] r_i,
  input  logic [1:0][M_W-1:0] m_i,
  input  logic [1:0][1:0]     main_sel_i,
  input  logic [1:0][1:0]     sec_sel_i,
  output logic                clk0_o,
  output logic                clk1_o,
  output logic                mfp_oe_o,
  output logic [R_W-1:0]      r_div_o,
  output logic [M_W-1:0]      m_div_o
);
  localparam int unsigned N_SYNC = 2;

  logic [N_SYNC-1:0] sync_d, sync_q;
  logic              fsel_s, en_s;
  pin_mode_e         mode;
  logic              run, gate, clk_mode;
  logic [P_W-1:0]    p_act;
  logic [1:0]        main_sel_act, sec_sel_act;

  assign sync_d = {mfp_i, fsel_i};

  // both pins idle high
  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i, .rst_ni, .d_i(sync_d[g]), .q_o(sync_q[g]));
  end

  assign fsel_s = sync_q[0];
  assign en_s   = sync_q[1];

  assign mode     = pin_mode_e'(pin_mode_i);
  assign clk_mode = (mode == PIN_CLK);
  assign run      = !((mode == PIN_PD) && !en_s);
  assign gate     = !(((mode == PIN_OE) || (mode == PIN_RSV)) && !en_s);
  assign mfp_oe_o = clk_mode;

  set_select #(.P_W(P_W), .R_W(R_W), .M_W(M_W)) u_set (
    .clk_i, .rst_ni,
    .fsel_s_i(fsel_s),
    .hold_i(clk0_o | clk1_o),
    .p_i, .r_i, .m_i, .main_sel_i, .sec_sel_i,
    .p_o(p_act), .r_o(r_div_o), .m_o(m_div_o),
    .main_sel_o(main_sel_act), .sec_sel_o(sec_sel_act));

  clk_route #(.P_W(P_W)) u_route (
    .clk_i, .rst_ni,
    .run_i(run), .gate_i(gate), .clk_mode_i(clk_mode),
    .ref_i, .p_i(p_act),
    .main_sel_i(main_sel_act), .sec_sel_i(sec_sel_act),
    .clk0_o, .clk1_o);
endmodule

// File: tb/clk_post_router_test.sv
module clk_post_router_test;
  localparam int P_W = 5;
  localparam int R_W = 8;
  localparam int M_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0;
  logic fsel = 1'b1;
  logic [1:0] pin_mode = 2'd0;
  logic mfp = 1'b1;
  logic [1:0][P_W-1:0] p_i;
  logic [1:0][R_W-1:0] r_i;
  logic [1:0][M_W-1:0] m_i;
  logic [1:0][1:0] main_sel, sec_sel;
  logic clk0, clk1, mfp_oe;
  logic [R_W-1:0] r_div;
  logic [M_W-1:0] m_div;

  int nvec = 0, nfail = 0;
  string req = "R12";
  bit cmp_en = 1'b0;
  int ref_per = 0, ref_cnt = 0;

  always #10 clk = ~clk;

  clk_post_router uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_i), .fsel_i(fsel),
    .pin_mode_i(pin_mode), .mfp_i(mfp), .p_i(p_i), .r_i(r_i), .m_i(m_i),
    .main_sel_i(main_sel), .sec_sel_i(sec_sel),
    .clk0_o(clk0), .clk1_o(clk1), .mfp_oe_o(mfp_oe),
    .r_div_o(r_div), .m_div_o(m_div));

  // reference clock generator
  always @(negedge clk) begin
    if (ref_per != 0) begin
      if (ref_cnt >= ref_per - 1) begin ref_cnt <= 0; ref_i <= ~ref_i; end
      else ref_cnt <= ref_cnt + 1;
    end
  end

  // behavioural reference model
  bit f1, f2, e1, e2, o0, o1, refr, refp, mp, vt, rt, rh, mh;
  int set, vc, rc;

  always @(posedge clk or negedge rst_n) begin
    bit run, gate, ck, tick, mainv, secv, n0, n1;
    int pv, lim, ms, ss;
    if (!rst_n) begin
      f1 = 1; f2 = 1; e1 = 1; e2 = 1; set = 0;
      o0 = 0; o1 = 0; refr = 0; refp = 0; mp = 0;
      vt = 0; rt = 0; rh = 0; mh = 0; vc = 0; rc = 0;
    end else begin
      run  = !(pin_mode == 1 && !e2);
      gate = !((pin_mode == 0 || pin_mode == 3) && !e2);
      ck   = (pin_mode == 2);
      pv   = int'(p_i[set]);
      lim  = (pv == 0) ? 1 : pv;
      ms   = int'(main_sel[set]);
      ss   = int'(sec_sel[set]);
      tick = refr && !refp;
      mainv = (ms == 1) ? refr : (ms == 2) ? rt : vt;
      case (ss)
        0: secv = refr;
        1: secv = rh;
        2: secv = mainv;
        default: secv = mh;
      endcase
      n0 = run && gate && mainv;
      n1 = run && gate && ck && secv;
      if (!o0 && !o1) set = f2 ? 0 : 1;
      if (!run) begin
        vc = 0; vt = 0; rc = 0; rt = 0; rh = 0; mh = 0;
        refr = 0; refp = 0; mp = 0;
      end else begin
        if (vc >= lim - 1) begin vc = 0; vt = !vt; end else vc++;
        if (tick) begin
          if (rc >= lim - 1) begin rc = 0; rt = !rt; end else rc++;
          rh = !rh;
        end
        if (mainv && !mp) mh = !mh;
        refp = refr; refr = ref_i; mp = mainv;
      end
      o0 = n0; o1 = n1;
      f2 = f1; f1 = fsel; e2 = e1; e1 = mfp;
    end
  end

  task automatic chk(string sig, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, sig, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      chk("clk0_o", int'(clk0), int'(o0));
      chk("clk1_o", int'(clk1), int'(o1));
      chk("mfp_oe_o", int'(mfp_oe), (pin_mode == 2) ? 1 : 0);
      chk("r_div_o", int'(r_div), int'(r_i[set]));
      chk("m_div_o", int'(m_div), int'(m_i[set]));
    end
  end

  task automatic run_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    p_i[0] = 5'd3;  r_i[0] = 8'h11; m_i[0] = 11'h123; main_sel[0] = 2'd0; sec_sel[0] = 2'd0;
    p_i[1] = 5'd5;  r_i[1] = 8'h2A; m_i[1] = 11'h456; main_sel[1] = 2'd2; sec_sel[1] = 2'd3;
    run_cycles(3);
    #1;
    // R12 reset state, R1 default set
    req = "R12"; chk("clk0_o", int'(clk0), 0);
    req = "R12"; chk("clk1_o", int'(clk1), 0);
    req = "R1";  chk("r_div_o", int'(r_div), 8'h11);
    req = "R1";  chk("m_div_o", int'(m_div), 11'h123);
    @(negedge clk); rst_n = 1'b1;
    cmp_en = 1'b1;

    req = "R3"; run_cycles(40);
    begin
      int highs = 0;
      for (int i = 0; i < 36; i++) begin
        @(negedge clk); #1;
        if (clk0) highs++;
      end
      chk("clk0_duty", highs, 18);
    end
    req = "R4"; p_i[0] = 5'd0; run_cycles(20);
    req = "R5"; p_i[0] = 5'd2; main_sel[0] = 2'd1; ref_per = 3; run_cycles(40);
    req = "R6"; main_sel[0] = 2'd2; run_cycles(80);
    req = "R10"; pin_mode = 2'd2; run_cycles(20);
    for (int s = 0; s < 4; s++) begin
      req = "R7"; sec_sel[0] = 2'(s); run_cycles(60);
    end
    req = "R3"; main_sel[0] = 2'd3; sec_sel[0] = 2'd3; run_cycles(40);
    req = "R1"; fsel = 1'b0; run_cycles(60);
    req = "R11"; fsel = 1'b1; run_cycles(60);
    req = "R2"; fsel = 1'b0; run_cycles(7); fsel = 1'b1; run_cycles(40);
    req = "R8"; pin_mode = 2'd0; mfp = 1'b0; run_cycles(30); mfp = 1'b1; run_cycles(30);
    req = "R8"; pin_mode = 2'd3; mfp = 1'b0; run_cycles(20); mfp = 1'b1; run_cycles(20);
    req = "R9"; pin_mode = 2'd1; mfp = 1'b0; run_cycles(30); mfp = 1'b1; run_cycles(40);
    req = "R2"; mfp = 1'b0; fsel = 1'b0; run_cycles(20); mfp = 1'b1; run_cycles(50);
    mfp = 1'b0; fsel = 1'b1; run_cycles(20); mfp = 1'b1; run_cycles(50);
    req = "R10"; pin_mode = 2'd2; run_cycles(60);
    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule